// File: doc/BRIEF.md
# Multi-Line External Interrupt Detector

This block watches a set of asynchronous external request lines and turns each into a per-line interrupt output for a downstream interrupt controller. Every line first passes through a two-flop synchroniser. It is then judged according to its own trigger setting: low level, falling edge, rising edge or both edges. A detection raises that line's bit in a status register, and the status bit drives the line's interrupt output directly.

Software reaches two registers through a plain register port: a single write strobe, an address and write data, plus combinational read data. The trigger register holds a 2-bit field per line. The status register is cleared by writing zero, and that clear is gated. It is honoured only for a line in an edge mode whose status bit is already set. A 1 in the write data leaves the bit alone. In level mode the status bit mirrors the synchronised input and ignores writes. No data stream passes through the block, so no port has valid/ready handshaking or back-pressure. Every write is accepted in the cycle its strobe is high.

Top module: `exti_detector`

## Requirements
- R1: After reset every status bit and every `irq_o` bit is 0, every trigger field is 00 (low level), and the synchroniser and previous-sample flops hold 1 (idle-high lines).
- R2: A write with `reg_we`=1 to address 0 loads the trigger register. Line i uses bits [2i+1:2i]. Address 0 reads the trigger register back, address 1 reads the status bits in [NUM_LINES-1:0] with upper bits 0, and any other address reads 0.
- R3: Field encoding: bit 0 enables falling-edge detection and bit 1 enables rising-edge detection, so 01 is falling, 10 is rising and 11 is both. A qualifying edge on the input sets the status bit on the third rising clock edge after the input changes (two synchroniser stages, then the status register).
- R4: With field 00 (low level), the status bit takes the inverse of the synchronised input on each clock, so it is 1 while the line is held low.
- R5: In low-level mode a write to the status register never changes that line's status bit.
- R6: In an edge mode, writing 0 to a set status bit clears it on the next clock.
- R7: Writing 1 to a status bit never changes it.
- R8: In an edge mode, writing 0 to a status bit that is already 0 leaves it 0.
- R9: If a qualifying edge and a valid clear fall in the same cycle, the bit ends up set.
- R10: A trigger write that changes a line's field clears that line's status on that clock and discards any edge seen in that cycle, so no false edge is reported afterwards.
- R11: `irq_o[i]` always equals status bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | Asynchronous external request lines |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register address (0 trigger, 1 status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq_o | output | NUM_LINES | Per-line interrupt request |

## Verification
A mixed trigger pattern across the lines (level, falling, rising, both) is driven through a full low-then-high swing of every input. One pass therefore separates the four modes and confirms the three-clock latency. Status writes with zero, with one and with partial masks tell an honoured clear apart from a write that is ignored because of level mode, an already-clear bit or a 1 in the data. Timed collisions place a clear, or a trigger change, in exactly the cycle an edge is seen, which exposes the set-priority and false-edge rules. A long seeded random run of line toggles and register writes is then compared every cycle against a reference model in the bench.

// File: rtl/exti_pkg.sv
package exti_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_mode_e;

  localparam int FALL_EN_BIT = 0;
  localparam int RISE_EN_BIT = 1;
  localparam int FIELD_W     = 2;

  localparam logic [1:0] ADDR_TRIG = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int   WIDTH   = 8,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/exti_regfile.sv
module exti_regfile
  import exti_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_LINES-1:0]       stat_i,
  output logic [FIELD_W*NUM_LINES-1:0] trig_o,
  output logic [NUM_LINES-1:0]       trig_chg_o,
  output logic                       stat_wr_o,
  output logic [NUM_LINES-1:0]       stat_wbits_o
);
  localparam int TRIG_W = FIELD_W * NUM_LINES;

  logic [TRIG_W-1:0] trig_q;
  logic              trig_we;

  assign trig_we      = reg_we && (reg_addr == ADDR_W'(ADDR_TRIG));
  assign stat_wr_o    = reg_we && (reg_addr == ADDR_W'(ADDR_STAT));
  assign stat_wbits_o = reg_wdata[NUM_LINES-1:0];
  assign trig_o       = trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_q <= '0;
    else if (trig_we) trig_q <= reg_wdata[TRIG_W-1:0];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chg
    assign trig_chg_o[i] = trig_we &&
      (reg_wdata[FIELD_W*i +: FIELD_W] != trig_q[FIELD_W*i +: FIELD_W]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_TRIG))      reg_rdata[TRIG_W-1:0]    = trig_q;
    else if (reg_addr == ADDR_W'(ADDR_STAT)) reg_rdata[NUM_LINES-1:0] = stat_i;
  end

  // R2: the trigger register only moves on a trigger write
  p_trig_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_we |=> $stable(trig_q));
  p_trig_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |=> trig_q == $past(reg_wdata[TRIG_W-1:0]));
endmodule

// File: rtl/exti_line.sv
module exti_line
  import exti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  trig_mode_e mode_i,
  input  logic       mode_chg_i,
  input  logic       stat_wr_i,
  input  logic       wbit_i,
  output logic       stat_o
);
  logic prev_q;
  logic stat_q;
  logic level_mode;
  logic rise_seen;
  logic fall_seen;
  logic hit;
  logic clr_ok;

  assign level_mode = (mode_i == TRIG_LOW);
  assign rise_seen  = sync_i & ~prev_q;
  assign fall_seen  = ~sync_i & prev_q;
  assign hit        = (mode_i[FALL_EN_BIT] & fall_seen) | (mode_i[RISE_EN_BIT] & rise_seen);
  assign clr_ok     = stat_wr_i & ~wbit_i & stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      stat_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (mode_chg_i)      stat_q <= 1'b0;
      else if (level_mode) stat_q <= ~sync_i;
      else if (hit)        stat_q <= 1'b1;
      else if (clr_ok)     stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R3: a qualifying edge in a stable edge mode sets the status
  p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && hit && !mode_chg_i) |=> stat_q);
  // R4: level mode mirrors the inverted synchronised input
  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !mode_chg_i) |=> (stat_q == !$past(sync_i)));
  // R6: an honoured clear drops the bit
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !mode_chg_i && !hit && stat_wr_i && !wbit_i && stat_q) |=> !stat_q);
  // R7: a one in the write data leaves an edge-mode bit unchanged
  p_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !mode_chg_i && !hit && stat_wr_i && wbit_i) |=> $stable(stat_q));
  // R8: a clear bit stays clear without an edge
  p_zero_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !mode_chg_i && !hit && !stat_q) |=> !stat_q);
  // R9: set beats a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !mode_chg_i && hit && stat_wr_i && !wbit_i) |=> stat_q);
  // R10: a trigger change clears the status
  p_chg_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_i |=> !stat_q);
endmodule

// File: rtl/exti_detector.sv
module exti_detector
  import exti_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 2 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int SYNC_STAGES = 2;
  localparam int TRIG_W      = FIELD_W * NUM_LINES;

  logic [NUM_LINES-1:0] line_sync;
  logic [TRIG_W-1:0]    trig;
  logic [NUM_LINES-1:0] trig_chg;
  logic                 stat_wr;
  logic [NUM_LINES-1:0] stat_wbits;
  logic [NUM_LINES-1:0] stat;

  exti_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (line_i),
    .dout(line_sync)
  );

  exti_regfile #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .stat_i      (stat),
    .trig_o      (trig),
    .trig_chg_o  (trig_chg),
    .stat_wr_o   (stat_wr),
    .stat_wbits_o(stat_wbits)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    exti_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (line_sync[i]),
      .mode_i    (trig_mode_e'(trig[FIELD_W*i +: FIELD_W])),
      .mode_chg_i(trig_chg[i]),
      .stat_wr_i (stat_wr),
      .wbit_i    (stat_wbits[i]),
      .stat_o    (stat[i])
    );
  end

  assign irq_o = stat;

  // R5: in level mode a status write cannot pull the bit away from the input
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    p_level_ignores_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[FIELD_W*i +: FIELD_W] == 2'b00 && !trig_chg[i] && stat_wr && !line_sync[i])
        |=> irq_o[i]);
  end
endmodule

// File: tb/exti_detector_bench.sv
module exti_detector_bench;
  localparam int N  = 8;
  localparam int AW = 2;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  line_i = '1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  irq_o;

  int n_run  = 0;
  int n_fail = 0;

  exti_detector #(.NUM_LINES(N), .ADDR_W(AW), .DATA_W(DW)) u_exti_detector (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // reference model built from the requirements
  logic [N-1:0]  m_s1, m_s2, m_prev, m_stat;
  logic [DW-1:0] m_type;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_prev = '1; m_stat = '0; m_type = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic [1:0] ty;
        logic chg, hit;
        ty  = m_type[2*i +: 2];
        chg = reg_we && reg_addr == 2'd0 && reg_wdata[2*i +: 2] != ty;
        hit = (ty[0] && !m_s2[i] && m_prev[i]) || (ty[1] && m_s2[i] && !m_prev[i]);
        if (chg) m_stat[i] = 1'b0;
        else if (ty == 2'b00) m_stat[i] = !m_s2[i];
        else if (hit) m_stat[i] = 1'b1;
        else if (reg_we && reg_addr == 2'd1 && !reg_wdata[i]) m_stat[i] = 1'b0;
      end
      if (reg_we && reg_addr == 2'd0) m_type = reg_wdata;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = line_i;
    end
  end

  function automatic logic [DW-1:0] exp_rdata();
    if (reg_addr == 2'd0) return m_type;
    if (reg_addr == 2'd1) return DW'(m_stat);
    return '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R11 irq vs model", 32'(irq_o), 32'(m_stat));
    chk("R2 rdata vs model", 32'(reg_rdata), 32'(exp_rdata()));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq_o), 32'h0);
    rst_n = 1'b1;
    cyc();
    chk("R1 status after reset", 32'(irq_o), 32'h0);
    chk("R1 trigger after reset", 32'(reg_rdata), 32'h0);

    // R2: trigger readback and address decode
    wr(2'd0, 16'hE4E4);
    reg_addr = 2'd0; cyc();
    chk("R2 trigger readback", 32'(reg_rdata), 32'hE4E4);
    reg_addr = 2'd2; cyc();
    chk("R2 unmapped reads 0", 32'(reg_rdata), 32'h0);
    reg_addr = 2'd1;

    // R3/R4: all lines low; mode per nibble: level, fall, rise, both
    line_i = 8'h00;
    cyc(); cyc();
    chk("R3 no change before third edge", 32'(irq_o), 32'h00);
    cyc();
    chk("R3 R4 falling swing", 32'(irq_o), 32'hBB);

    wr(2'd1, 16'h0000);
    chk("R6 R5 R8 clear honoured only for set edge bits", 32'(irq_o), 32'h11);
    wr(2'd1, 16'h00FF);
    chk("R7 ones write keeps status", 32'(irq_o), 32'h11);

    line_i = 8'hFF;
    cyc(); cyc(); cyc();
    chk("R3 R4 rising swing", 32'(irq_o), 32'hCC);
    wr(2'd1, 16'h00FF);
    chk("R7 ones write keeps edge bits", 32'(irq_o), 32'hCC);
    wr(2'd1, 16'h00BB);
    chk("R6 partial clear", 32'(irq_o), 32'h88);
    wr(2'd1, 16'h0000);
    chk("R6 full clear", 32'(irq_o), 32'h00);

    // R9: clear lands in the same cycle as a new edge on line 3
    line_i = 8'hF7;
    cyc(); cyc(); cyc();
    chk("R3 both-edge mode sees fall", 32'(irq_o), 32'h08);
    line_i = 8'hFF;
    cyc(); cyc();
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0000;
    cyc();
    reg_we = 1'b0;
    chk("R9 set wins over clear", 32'(irq_o), 32'h08);

    // R10: trigger change clears status
    wr(2'd0, 16'hE464);
    chk("R10 change clears status", 32'(irq_o), 32'h00);
    line_i = 8'hF7;
    cyc(); cyc();
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'hE4E4;
    cyc();
    reg_we = 1'b0; reg_addr = 2'd1;
    chk("R10 edge discarded on change", 32'(irq_o), 32'h00);
    cyc(); cyc();
    chk("R10 no false edge later", 32'(irq_o), 32'h00);

    // R4/R5: switch line 3 to level while low
    wr(2'd0, 16'hE424);
    chk("R10 change to level clears", 32'(irq_o), 32'h00);
    cyc();
    chk("R4 level follows low input", 32'(irq_o), 32'h08);
    wr(2'd1, 16'h0000);
    chk("R5 level ignores clear", 32'(irq_o), 32'h08);
    line_i = 8'hFF;
    cyc(); cyc(); cyc();
    chk("R4 level released", 32'(irq_o), 32'h00);

    // seeded random mix
    for (int k = 0; k < 4000; k++) begin
      line_i    = line_i ^ N'($urandom & $urandom & $urandom);
      reg_we    = ($urandom % 4) == 0;
      reg_addr  = AW'(($urandom % 5 == 0) ? 0 : (($urandom % 4 == 0) ? 2 : 1));
      reg_wdata = DW'($urandom);
      cyc();
    end
    reg_we = 1'b0;
    cyc();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule